// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end of a 5-bit step attenuator. It turns one of three loading methods into a registered 5-bit attenuation code for the switch array. The code is in 1 dB units, from 0 to 31 dB. A single mode input picks the method. When it is high, a three-wire serial stream is used: data, serial clock and latch enable. The serial bits fill an 8-bit shift register, and a rising latch enable moves the word's attenuation field to the output. When the mode input is low, five parallel lines drive the code. These lines either pass straight through while latch enable is high, or are held while latch enable is low, so a high-then-low pulse captures a value.

Every control input is asynchronous to the block's fast system clock. Each one passes through a two-flop synchronizer. Edges on the serial clock and on latch enable are found from the synchronized copies, so no logic is clocked by a control pin. Reset puts the output at full attenuation. A sticky flag reports latched serial words that carry ones in their reserved positions, and a one-cycle strobe marks every change of the applied code.

Top module: `step_atten_ctrl`

## Requirements
- R1: While synchronous reset is high and in the cycle after, `atten_o` is 31, and `atten_chg_o` and `word_err_o` are 0. With latch enable low, the output stays at 31 until a value is loaded.
- R2: `mode_ser_i` high selects the serial path and low selects the parallel path. In serial mode, `par_i` has no effect on `atten_o`.
- R3: The serial register takes one bit from `sdata_i` on each rising edge of `sclk_i` while in serial mode. Bits enter least significant first, so after eight edges the first bit sent sits at bit 0.
- R4: In serial mode, shifting with latch enable low never changes `atten_o`.
- R5: A rising edge of `latch_i` in serial mode copies bits 6..2 of the serial word to `atten_o`. Bit 2 weighs 1 dB and bit 6 weighs 16 dB.
- R6: `par_i` bit k weighs 2^k dB: bit 0 is 1 dB and bit 4 is 16 dB.
- R7: In parallel mode with latch enable held high, `atten_o` follows `par_i`. A change shows 3 clock edges after it is sampled.
- R8: In parallel mode with latch enable low, `atten_o` holds. After a high-then-low pulse it shows the value present during the pulse.
- R9: A serial latch of a word that has any of bits 0, 1 or 7 set raises `word_err_o`, and bits 6..2 are still applied. The flag stays high until reset.
- R10: `atten_chg_o` is high for exactly one cycle, in the first cycle that a new `atten_o` value is shown, and never when the value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all control inputs |
| rst | input | 1 | Synchronous active-high reset |
| mode_ser_i | input | 1 | 1 = serial loading, 0 = parallel loading |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock (sampled) |
| latch_i | input | 1 | Latch enable |
| par_i | input | 5 | Parallel attenuation lines, bit k = 2^k dB |
| atten_o | output | 5 | Applied attenuation code in dB |
| atten_chg_o | output | 1 | One-cycle strobe on a change of atten_o |
| word_err_o | output | 1 | Sticky flag: reserved serial bits were set |

## Verification
The properties check on every cycle that the code stays put in serial mode without a latch rising edge, and in parallel mode while latch enable is low. They also check that the code tracks the synchronized parallel lines while latch enable is high, that the change strobe matches every output change exactly, that the error flag never falls, and that reset gives full attenuation. The bench scenarios are the only place to see that bit order is least significant first, that the field sits in bits 6..2, that reserved bits set the flag while the field still applies, that the parallel lines are ignored in serial mode, and that a latched pulse captures the right value through the synchronizer delay.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int ATTEN_W_DEF     = 5;
  localparam int WORD_W_DEF      = 8;
  localparam int FIELD_LSB_DEF   = 2;
  localparam int SYNC_STAGES_DEF = 2;

  // Which source loads the applied attenuation this cycle
  typedef enum logic [1:0] {
    LD_HOLD     = 2'd0,
    LD_SERIAL   = 2'd1,
    LD_PARALLEL = 2'd2
  } load_src_e;
endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sac_edge.sv
module sac_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise_o[b] = lvl_i[b] & ~prev_q[b];
  end
endmodule

// File: rtl/sac_shifter.sv
module sac_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  // New bits enter at the top and move down, so the first bit ends at bit 0
  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[WORD_W-1:1]};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/sac_apply.sv
module sac_apply
  import sac_pkg::*;
#(
  parameter int ATTEN_W   = 5,
  parameter int WORD_W    = 8,
  parameter int FIELD_LSB = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_ser_i,
  input  logic               le_lvl_i,
  input  logic               le_rise_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [ATTEN_W-1:0] par_i,
  output logic [ATTEN_W-1:0] atten_o,
  output logic               chg_o,
  output logic               err_o
);
  localparam logic [WORD_W-1:0] FIELD_MASK =
    WORD_W'(((1 << ATTEN_W) - 1) << FIELD_LSB);

  load_src_e          src;
  logic [ATTEN_W-1:0] atten_q, atten_nxt;
  logic               chg_q, err_q, err_hit;

  always_comb begin
    if (mode_ser_i) src = le_rise_i ? LD_SERIAL : LD_HOLD;
    else            src = le_lvl_i  ? LD_PARALLEL : LD_HOLD;
  end

  always_comb begin
    atten_nxt = atten_q;
    err_hit   = 1'b0;
    unique case (src)
      LD_SERIAL: begin
        atten_nxt = word_i[FIELD_LSB +: ATTEN_W];
        err_hit   = |(word_i & ~FIELD_MASK);
      end
      LD_PARALLEL: atten_nxt = par_i;
      default: atten_nxt = atten_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      atten_q <= '1;
      chg_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      atten_q <= atten_nxt;
      chg_q   <= (atten_nxt != atten_q);
      err_q   <= err_q | err_hit;
    end
  end

  assign atten_o = atten_q;
  assign chg_o   = chg_q;
  assign err_o   = err_q;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import sac_pkg::*;
#(
  parameter int ATTEN_W     = ATTEN_W_DEF,
  parameter int WORD_W      = WORD_W_DEF,
  parameter int FIELD_LSB   = FIELD_LSB_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_ser_i,
  input  logic               sdata_i,
  input  logic               sclk_i,
  input  logic               latch_i,
  input  logic [ATTEN_W-1:0] par_i,
  output logic [ATTEN_W-1:0] atten_o,
  output logic               atten_chg_o,
  output logic               word_err_o
);
  localparam int SYNC_W     = ATTEN_W + 4;
  localparam int IDX_MODE   = SYNC_W - 1;
  localparam int IDX_LE     = SYNC_W - 2;
  localparam int IDX_SCLK   = SYNC_W - 3;
  localparam int IDX_SDATA  = SYNC_W - 4;

  logic [SYNC_W-1:0]  sync_q;
  logic               mode_s, le_s, sclk_s, sdata_s;
  logic [ATTEN_W-1:0] par_s;
  logic [1:0]         rise;
  logic               le_rise, sclk_rise;
  logic [WORD_W-1:0]  word;

  sac_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({mode_ser_i, latch_i, sclk_i, sdata_i, par_i}),
    .q_o (sync_q)
  );

  assign mode_s  = sync_q[IDX_MODE];
  assign le_s    = sync_q[IDX_LE];
  assign sclk_s  = sync_q[IDX_SCLK];
  assign sdata_s = sync_q[IDX_SDATA];
  assign par_s   = sync_q[ATTEN_W-1:0];

  sac_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({le_s, sclk_s}),
    .rise_o (rise)
  );

  assign le_rise   = rise[1];
  assign sclk_rise = rise[0];

  sac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (mode_s & sclk_rise),
    .bit_i   (sdata_s),
    .word_o  (word)
  );

  sac_apply #(.ATTEN_W(ATTEN_W), .WORD_W(WORD_W), .FIELD_LSB(FIELD_LSB)) u_apply (
    .clk        (clk),
    .rst        (rst),
    .mode_ser_i (mode_s),
    .le_lvl_i   (le_s),
    .le_rise_i  (le_rise),
    .word_i     (word),
    .par_i      (par_s),
    .atten_o    (atten_o),
    .chg_o      (atten_chg_o),
    .err_o      (word_err_o)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int ATTEN_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [ATTEN_W-1:0] atten_o,
  input logic               atten_chg_o,
  input logic               word_err_o,
  input logic               mode_s,
  input logic               le_s,
  input logic               le_rise,
  input logic [ATTEN_W-1:0] par_s
);
  // R1: reset gives full attenuation, no strobe, no flag
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (atten_o == '1 && !atten_chg_o && !word_err_o));

  // R4: serial mode without a latch rising edge leaves the output alone
  a_r4_serial_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_s && !le_rise) |=> $stable(atten_o));

  // R8: parallel mode with latch enable low holds the output
  a_r8_parallel_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !le_s) |=> $stable(atten_o));

  // R7: parallel mode with latch enable high tracks the synchronized lines
  a_r7_direct_follow: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && le_s) |=> (atten_o == $past(par_s)));

  // R9: the error flag never falls outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    word_err_o |=> word_err_o);

  // R10: a change of the output comes with the strobe
  a_r10_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(atten_o) |-> atten_chg_o);

  // R10: no strobe while the output is unchanged
  a_r10_no_idle_strobe: assert property (@(posedge clk) disable iff (rst)
    $stable(atten_o) |-> !atten_chg_o);
endmodule

bind step_atten_ctrl sac_checker #(.ATTEN_W(ATTEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .atten_o     (atten_o),
  .atten_chg_o (atten_chg_o),
  .word_err_o  (word_err_o),
  .mode_s      (mode_s),
  .le_s        (le_s),
  .le_rise     (le_rise),
  .par_s       (par_s)
);

// File: tb/step_atten_ctrl_test.sv
`timescale 1ns/1ps
module step_atten_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_ser_i = 1'b0, sdata_i = 1'b0, sclk_i = 1'b0, latch_i = 1'b0;
  logic [4:0] par_i = '0;
  logic [4:0] atten_o;
  logic       atten_chg_o, word_err_o;

  int n_chk = 0, n_bad = 0, strobes = 0;
  logic [4:0] exp_atten = 5'd31;
  logic       exp_err   = 1'b0;
  bit         done      = 1'b0;

  always #2.5 clk = ~clk;

  step_atten_ctrl uut (
    .clk(clk), .rst(rst), .mode_ser_i(mode_ser_i), .sdata_i(sdata_i),
    .sclk_i(sclk_i), .latch_i(latch_i), .par_i(par_i),
    .atten_o(atten_o), .atten_chg_o(atten_chg_o), .word_err_o(word_err_o)
  );

  always @(negedge clk) if (atten_chg_o) strobes++;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Field of a serial word: bits 6..2, bit 2 = 1 dB
  function automatic logic [4:0] word_field(input logic [7:0] w);
    return {w[6], w[5], w[4], w[3], w[2]};
  endfunction

  function automatic logic word_bad(input logic [7:0] w);
    return w[0] | w[1] | w[7];
  endfunction

  task automatic do_serial(input logic [7:0] w, input logic [4:0] junk_par);
    int s0 = strobes;
    logic [4:0] nv = word_field(w);
    mode_ser_i = 1'b1; latch_i = 1'b0; par_i = junk_par;
    wait_cyc(4);
    for (int i = 0; i < 8; i++) begin
      sdata_i = w[i];
      wait_cyc(4); sclk_i = 1'b1;
      wait_cyc(4); sclk_i = 1'b0;
    end
    wait_cyc(4);
    check("R4 serial shift held output", atten_o, exp_atten);
    check("R2 parallel lines ignored in serial", atten_o, exp_atten);
    latch_i = 1'b1; wait_cyc(4);
    latch_i = 1'b0; wait_cyc(4);
    if (word_bad(w)) exp_err = 1'b1;
    check("R5 R3 serial field applied", atten_o, nv);
    check("R9 error flag", word_err_o, exp_err);
    check("R10 strobe count serial", strobes - s0, (nv != exp_atten) ? 1 : 0);
    exp_atten = nv;
  endtask

  task automatic do_latched(input logic [4:0] v);
    int s0 = strobes;
    mode_ser_i = 1'b0; latch_i = 1'b0;
    wait_cyc(4);
    par_i = v; wait_cyc(5);
    check("R8 latched hold before pulse", atten_o, exp_atten);
    latch_i = 1'b1; wait_cyc(4);
    latch_i = 1'b0; par_i = ~v; wait_cyc(5);
    check("R8 R6 latched capture", atten_o, v);
    check("R10 strobe count latched", strobes - s0, (v != exp_atten) ? 1 : 0);
    exp_atten = v;
  endtask

  task automatic do_direct(input logic [4:0] v1, input logic [4:0] v2);
    int s0 = strobes;
    int nexp = 0;
    mode_ser_i = 1'b0; latch_i = 1'b0;
    wait_cyc(4);
    par_i = v1; wait_cyc(4);
    latch_i = 1'b1; wait_cyc(4);
    check("R7 direct follow first", atten_o, v1);
    par_i = v2; wait_cyc(4);
    check("R7 direct follow second", atten_o, v2);
    latch_i = 1'b0; wait_cyc(4);
    par_i = ~v2; wait_cyc(5);
    check("R8 hold after direct", atten_o, v2);
    nexp = ((v1 != exp_atten) ? 1 : 0) + ((v2 != v1) ? 1 : 0);
    check("R10 strobe count direct", strobes - s0, nexp);
    exp_atten = v2;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 reset atten", atten_o, 31);
    check("R1 reset flag", word_err_o, 0);
    check("R10 reset strobe", atten_chg_o, 0);
    par_i = 5'b00101; wait_cyc(8);
    check("R1 holds until loaded", atten_o, 31);

    // R6: each parallel weight alone, then the extremes
    for (int k = 0; k < 5; k++) do_latched(5'(1 << k));
    do_latched(5'd0);
    do_latched(5'd31);

    // R3/R5: 13 dB word 0b00110100, then single serial weights
    do_serial(8'h34, 5'd7);
    check("R5 13 dB word", atten_o, 13);
    do_serial(8'h04, 5'd31);
    do_serial(8'h40, 5'd0);
    do_serial(8'h40, 5'd3);

    // R9: reserved bits set, field still applied, flag sticky
    do_serial(8'h81, 5'd0);
    do_serial(8'h18, 5'd9);
    check("R9 flag stays high", word_err_o, 1);

    do_direct(5'd17, 5'd17);
    do_direct(5'd2, 5'd30);

    // R1: reset mid-run restores full attenuation and clears the flag
    rst = 1'b1; wait_cyc(3); rst = 1'b0; wait_cyc(1);
    exp_atten = 5'd31; exp_err = 1'b0;
    check("R1 reset again atten", atten_o, 31);
    check("R1 reset again flag", word_err_o, 0);

    for (int it = 0; it < 40; it++) begin
      int unsigned op = $urandom % 3;
      logic [7:0] w = 8'($urandom);
      if (($urandom % 4) != 0) w = w & 8'h7C;
      case (op)
        0: do_serial(w, 5'($urandom));
        1: do_latched(5'($urandom));
        default: do_direct(5'($urandom), 5'($urandom));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule